// File: doc/BRIEF.md
# Interprocessor and Timer Interrupt Controller

The block holds, for each of four processors, one pending interprocessor-interrupt bit and one pending interval-timer bit, and drives each as a level output toward that processor. Software reaches the block through a single-word register port with 64-bit data. A shared control register carries three separate 4-bit processor masks, so one write can raise interprocessor interrupts, drop others and acknowledge timer interrupts at once. Three dedicated registers each do one of the post, clear or acknowledge operations by mask, and they also return the pending masks on a read.

A periodic tick input, made elsewhere, marks a timer interrupt pending for every processor. Every access gets a response one cycle later with an error flag. Two per-processor strobes report redundant operations: posting an interprocessor interrupt that is already pending, and clearing one that is not.

Top module: `ipi_timer_intc`

## Requirements
- R1: While `rst` is high and in the cycle after it, all pending bits, both interrupt outputs, both warning strobes and `rsp_valid` are zero.
- R2: A write to the control register (index 0) sets the interprocessor pending bit of each processor whose bit is set in data bits 15:12. A processor that was already pending stays pending, and its `warn_ipi_dup` bit pulses in the response cycle.
- R3: In the same write, data bits 11:8 clear interprocessor pending bits. A clear is applied after the request of the same write, so a processor named in both ends up cleared. A clear for a processor that is neither pending nor requested in that write pulses its `warn_ipi_spur` bit.
- R4: In the same write, data bits 7:4 clear timer pending bits. Clearing a timer bit that is not pending has no effect and raises no error.
- R5: A control-register write with bits 15:4 all zero is accepted without error and without effect when data bit 28 is set. Without bit 28 it is answered with `rsp_err` and changes nothing.
- R6: A high `tick` sets the timer pending bit of every processor. If a tick and a timer clear for the same processor come in the same cycle, the bit ends up set.
- R7: Writes to index 3 post, to index 1 clear interprocessor, and to index 2 clear timer interrupts, each by the mask in data bits 3:0. A zero mask on any of them is answered with `rsp_err` and changes nothing.
- R8: A read of index 1 or 3 returns the interprocessor pending mask in bits 3:0, and a read of index 2 returns the timer pending mask in bits 3:0. A read of index 0 returns the interprocessor mask in bits 11:8, the timer mask in bits 7:4 and `acc_cpu` in bits 1:0. All other bits read as zero.
- R9: An access to index 4 to 7 is answered with `rsp_err` and read data zero, and it changes no state.
- R10: Every access gets exactly one `rsp_valid` pulse in the following cycle. `ipi_irq` and `tmr_irq` equal the pending masks, which update on the same edge.
- R11: The dedicated registers report redundancy with the same rules: posting a pending processor pulses `warn_ipi_dup`, and clearing a non-pending one pulses `warn_ipi_spur`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_idx | input | 3 | Register index |
| acc_wdata | input | 64 | Write data |
| acc_cpu | input | 2 | Number of the requesting processor |
| tick | input | 1 | Interval-timer tick |
| rsp_valid | output | 1 | Response strobe, one cycle after the access |
| rsp_rdata | output | 64 | Read data of the response |
| rsp_err | output | 1 | Unsupported or malformed access |
| ipi_irq | output | 4 | Interprocessor interrupt level per processor |
| tmr_irq | output | 4 | Timer interrupt level per processor |
| warn_ipi_dup | output | 4 | Post of an already pending interprocessor interrupt |
| warn_ipi_spur | output | 4 | Clear of a non-pending interprocessor interrupt |

## Verification
On every cycle, the assertions check four things. A post leaves its bits set. A clear leaves its bits cleared, and a tick fills the timer mask. Timer bits rise only after a tick, and duplicate warnings only name processors that were pending. Errored accesses leave the interprocessor mask alone, and responses follow accesses one for one. What the assertions cannot show comes from the bench's stateful scenarios: the clear-after-request ordering inside one control write, the exact read-back layouts, the bit-28 accept case, and the tick beating a same-cycle timer clear.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NCPU    = 4;
    localparam int DW      = 64;
    localparam int IDXW    = 3;
    localparam int CPUW    = $clog2(NCPU);

    // control-register field positions (software-visible)
    localparam int F_IPI_REQ = 12;
    localparam int F_IPI_CLR = 8;
    localparam int F_TMR_CLR = 4;
    localparam int F_ACCEPT  = 28;
    localparam int F_RD_IPI  = 8;
    localparam int F_RD_TMR  = 4;

    typedef enum logic [IDXW-1:0] {
        REG_CTRL     = 3'd0,
        REG_IPI_PEND = 3'd1,
        REG_TMR_PEND = 3'd2,
        REG_IPI_POST = 3'd3
    } reg_e;

    typedef logic [NCPU-1:0] cpu_mask_t;

    typedef struct packed {
        cpu_mask_t ipi_set;
        cpu_mask_t ipi_clr;
        cpu_mask_t tmr_clr;
    } intc_cmd_t;

    typedef struct packed {
        logic          valid;
        logic          err;
        logic [DW-1:0] rdata;
    } intc_rsp_t;

    function automatic logic [DW-1:0] ctrl_readback(cpu_mask_t ipi, cpu_mask_t tmr,
                                                    logic [CPUW-1:0] cpu);
        logic [DW-1:0] v;
        v = '0;
        v[F_RD_IPI +: NCPU] = ipi;
        v[F_RD_TMR +: NCPU] = tmr;
        v[CPUW-1:0]         = cpu;
        return v;
    endfunction

    function automatic logic [DW-1:0] mask_readback(cpu_mask_t m);
        logic [DW-1:0] v;
        v = '0;
        v[NCPU-1:0] = m;
        return v;
    endfunction
endpackage

// File: rtl/intc_regdec.sv
module intc_regdec
    import intc_pkg::*;
(
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic [IDXW-1:0]      acc_idx,
    input  logic [DW-1:0]        acc_wdata,
    input  logic [CPUW-1:0]      acc_cpu,
    input  cpu_mask_t            ipi_pend,
    input  cpu_mask_t            tmr_pend,
    output intc_cmd_t            cmd,
    output logic                 dec_err,
    output logic [DW-1:0]        dec_rdata
);
    cpu_mask_t f_req, f_clr, f_tclr, f_mask;
    logic      f_accept;

    assign f_req    = acc_wdata[F_IPI_REQ +: NCPU];
    assign f_clr    = acc_wdata[F_IPI_CLR +: NCPU];
    assign f_tclr   = acc_wdata[F_TMR_CLR +: NCPU];
    assign f_mask   = acc_wdata[NCPU-1:0];
    assign f_accept = acc_wdata[F_ACCEPT];

    always_comb begin
        cmd       = '0;
        dec_err   = 1'b0;
        dec_rdata = '0;
        if (acc_valid) begin
            case (acc_idx)
                REG_CTRL: begin
                    if (acc_write) begin
                        if ((f_req | f_clr | f_tclr) == '0 && !f_accept) begin
                            dec_err = 1'b1;
                        end else begin
                            cmd.ipi_set = f_req;
                            cmd.ipi_clr = f_clr;
                            cmd.tmr_clr = f_tclr;
                        end
                    end else begin
                        dec_rdata = ctrl_readback(ipi_pend, tmr_pend, acc_cpu);
                    end
                end
                REG_IPI_PEND: begin
                    if (acc_write) begin
                        if (f_mask == '0) dec_err = 1'b1;
                        else              cmd.ipi_clr = f_mask;
                    end else begin
                        dec_rdata = mask_readback(ipi_pend);
                    end
                end
                REG_TMR_PEND: begin
                    if (acc_write) begin
                        if (f_mask == '0) dec_err = 1'b1;
                        else              cmd.tmr_clr = f_mask;
                    end else begin
                        dec_rdata = mask_readback(tmr_pend);
                    end
                end
                REG_IPI_POST: begin
                    if (acc_write) begin
                        if (f_mask == '0) dec_err = 1'b1;
                        else              cmd.ipi_set = f_mask;
                    end else begin
                        dec_rdata = mask_readback(ipi_pend);
                    end
                end
                default: dec_err = 1'b1;
            endcase
        end
    end

    // R9: an errored access never produces a command
    always_comb begin
        a_r9_err_no_cmd: assert (!(dec_err && cmd != '0));
    end
endmodule

// File: rtl/intc_ipi_bank.sv
module intc_ipi_bank
    import intc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cpu_mask_t set_m,
    input  cpu_mask_t clr_m,
    output cpu_mask_t pend,
    output cpu_mask_t warn_dup,
    output cpu_mask_t warn_spur
);
    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        always_ff @(posedge clk) begin
            if (rst) begin
                pend[c]      <= 1'b0;
                warn_dup[c]  <= 1'b0;
                warn_spur[c] <= 1'b0;
            end else begin
                pend[c]      <= (pend[c] | set_m[c]) & ~clr_m[c];
                warn_dup[c]  <= set_m[c] & pend[c];
                warn_spur[c] <= clr_m[c] & ~(pend[c] | set_m[c]);
            end
        end
    end

    // R2: a request not cancelled by a clear leaves the bit set
    a_r2_post_sets: assert property (@(posedge clk) disable iff (rst)
        ((set_m & ~clr_m) != '0) |=> ((pend & $past(set_m & ~clr_m)) == $past(set_m & ~clr_m)));
    // R3: a clear always leaves the bit cleared
    a_r3_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (clr_m != '0) |=> ((pend & $past(clr_m)) == '0));
    // R11: duplicate warnings name only processors that were pending
    a_r11_dup_was_pending: assert property (@(posedge clk) disable iff (rst)
        (warn_dup != '0) |-> ((warn_dup & ~$past(pend)) == '0));
    // R11: spurious-clear warnings name only processors now clear
    a_r11_spur_now_clear: assert property (@(posedge clk) disable iff (rst)
        (warn_spur != '0) |-> ((warn_spur & pend) == '0));
endmodule

// File: rtl/intc_tmr_bank.sv
module intc_tmr_bank
    import intc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  cpu_mask_t clr_m,
    output cpu_mask_t pend
);
    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        always_ff @(posedge clk) begin
            if (rst)       pend[c] <= 1'b0;
            else if (tick) pend[c] <= 1'b1;
            else           pend[c] <= pend[c] & ~clr_m[c];
        end
    end

    // R6: a tick fills every timer bit, even against a clear
    a_r6_tick_fills: assert property (@(posedge clk) disable iff (rst)
        tick |=> (pend == '1));
    // R4: timer bits only rise because of a tick
    a_r4_rise_needs_tick: assert property (@(posedge clk) disable iff (rst)
        ((pend & ~$past(pend)) != '0) |-> $past(tick));
endmodule

// File: rtl/ipi_timer_intc.sv
module ipi_timer_intc
    import intc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic [IDXW-1:0]      acc_idx,
    input  logic [DW-1:0]        acc_wdata,
    input  logic [CPUW-1:0]      acc_cpu,
    input  logic                 tick,
    output logic                 rsp_valid,
    output logic [DW-1:0]        rsp_rdata,
    output logic                 rsp_err,
    output logic [NCPU-1:0]      ipi_irq,
    output logic [NCPU-1:0]      tmr_irq,
    output logic [NCPU-1:0]      warn_ipi_dup,
    output logic [NCPU-1:0]      warn_ipi_spur
);
    intc_cmd_t     cmd;
    logic          dec_err;
    logic [DW-1:0] dec_rdata;
    cpu_mask_t     ipi_pend, tmr_pend;
    intc_rsp_t     rsp_q;

    intc_regdec u_dec (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_idx   (acc_idx),
        .acc_wdata (acc_wdata),
        .acc_cpu   (acc_cpu),
        .ipi_pend  (ipi_pend),
        .tmr_pend  (tmr_pend),
        .cmd       (cmd),
        .dec_err   (dec_err),
        .dec_rdata (dec_rdata)
    );

    intc_ipi_bank u_ipi (
        .clk       (clk),
        .rst       (rst),
        .set_m     (cmd.ipi_set),
        .clr_m     (cmd.ipi_clr),
        .pend      (ipi_pend),
        .warn_dup  (warn_ipi_dup),
        .warn_spur (warn_ipi_spur)
    );

    intc_tmr_bank u_tmr (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .clr_m (cmd.tmr_clr),
        .pend  (tmr_pend)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid <= acc_valid;
            rsp_q.err   <= dec_err;
            rsp_q.rdata <= dec_rdata;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.rdata;
    assign ipi_irq   = ipi_pend;
    assign tmr_irq   = tmr_pend;

    // R10: one response per access, in the next cycle
    a_r10_rsp_follows: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> rsp_valid);
    a_r10_no_rsp_idle: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !rsp_valid);
    // R9: an errored access leaves the interprocessor mask untouched
    a_r9_err_keeps_ipi: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (ipi_irq == $past(ipi_irq)));
    // R8: a control-register read returns the requester number
    a_r8_cpu_field: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && acc_idx == REG_CTRL) |=> (rsp_rdata[CPUW-1:0] == $past(acc_cpu)));
endmodule

// File: tb/ipi_timer_intc_tb.sv
`timescale 1ns/1ps
module ipi_timer_intc_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid, acc_write, tick;
    logic [2:0]  acc_idx;
    logic [63:0] acc_wdata;
    logic [1:0]  acc_cpu;
    logic        rsp_valid, rsp_err;
    logic [63:0] rsp_rdata;
    logic [3:0]  ipi_irq, tmr_irq, warn_ipi_dup, warn_ipi_spur;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    ipi_timer_intc u_dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_idx(acc_idx), .acc_wdata(acc_wdata), .acc_cpu(acc_cpu), .tick(tick),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .ipi_irq(ipi_irq), .tmr_irq(tmr_irq),
        .warn_ipi_dup(warn_ipi_dup), .warn_ipi_spur(warn_ipi_spur)
    );

    typedef struct packed {
        logic        acc;
        logic        wr;
        logic [2:0]  idx;
        logic [31:0] wd;
        logic [1:0]  cpu;
        logic        tk;
        logic [3:0]  e_ipi;
        logic [3:0]  e_tmr;
        logic        e_err;
        logic [3:0]  e_dup;
        logic [3:0]  e_spur;
        logic [15:0] e_rd;
        logic [23:0] tag;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        // acc wr idx  wdata          cpu tk  ipi   tmr   err  dup   spur  rdata    tag
        '{1'b1,1'b1,3'd0,32'h0000_5000,2'd0,1'b0,4'h5,4'h0,1'b0,4'h0,4'h0,16'h0000,"R2"},
        '{1'b1,1'b1,3'd0,32'h0000_6000,2'd0,1'b0,4'h7,4'h0,1'b0,4'h4,4'h0,16'h0000,"R2"},
        '{1'b1,1'b1,3'd0,32'h0000_0900,2'd0,1'b0,4'h6,4'h0,1'b0,4'h0,4'h8,16'h0000,"R3"},
        '{1'b0,1'b0,3'd0,32'h0000_0000,2'd0,1'b1,4'h6,4'hF,1'b0,4'h0,4'h0,16'h0000,"R6"},
        '{1'b1,1'b1,3'd0,32'h0000_0030,2'd0,1'b0,4'h6,4'hC,1'b0,4'h0,4'h0,16'h0000,"R4"},
        '{1'b1,1'b1,3'd0,32'h1000_0000,2'd0,1'b0,4'h6,4'hC,1'b0,4'h0,4'h0,16'h0000,"R5"},
        '{1'b1,1'b1,3'd0,32'h0000_0001,2'd0,1'b0,4'h6,4'hC,1'b1,4'h0,4'h0,16'h0000,"R5"},
        '{1'b1,1'b0,3'd0,32'h0000_0000,2'd2,1'b0,4'h6,4'hC,1'b0,4'h0,4'h0,16'h06C2,"R8"},
        '{1'b1,1'b1,3'd1,32'h0000_0002,2'd0,1'b0,4'h4,4'hC,1'b0,4'h0,4'h0,16'h0000,"R7"},
        '{1'b1,1'b1,3'd3,32'h0000_0000,2'd0,1'b0,4'h4,4'hC,1'b1,4'h0,4'h0,16'h0000,"R7"},
        '{1'b1,1'b1,3'd3,32'h0000_0009,2'd0,1'b0,4'hD,4'hC,1'b0,4'h0,4'h0,16'h0000,"R7"},
        '{1'b1,1'b0,3'd1,32'h0000_0000,2'd0,1'b0,4'hD,4'hC,1'b0,4'h0,4'h0,16'h000D,"R8"},
        '{1'b1,1'b0,3'd2,32'h0000_0000,2'd0,1'b0,4'hD,4'hC,1'b0,4'h0,4'h0,16'h000C,"R8"},
        '{1'b1,1'b1,3'd2,32'h0000_0004,2'd0,1'b1,4'hD,4'hF,1'b0,4'h0,4'h0,16'h0000,"R6"},
        '{1'b1,1'b1,3'd2,32'h0000_0005,2'd0,1'b0,4'hD,4'hA,1'b0,4'h0,4'h0,16'h0000,"R7"},
        '{1'b1,1'b1,3'd0,32'h0000_2180,2'd0,1'b0,4'hE,4'h2,1'b0,4'h0,4'h0,16'h0000,"R2"},
        '{1'b1,1'b1,3'd0,32'h0000_0040,2'd0,1'b0,4'hE,4'h2,1'b0,4'h0,4'h0,16'h0000,"R4"},
        '{1'b1,1'b1,3'd0,32'h0000_4400,2'd0,1'b0,4'hA,4'h2,1'b0,4'h4,4'h0,16'h0000,"R3"},
        '{1'b1,1'b1,3'd0,32'h0000_1100,2'd0,1'b0,4'hA,4'h2,1'b0,4'h0,4'h0,16'h0000,"R3"},
        '{1'b1,1'b0,3'd5,32'h0000_0000,2'd0,1'b0,4'hA,4'h2,1'b1,4'h0,4'h0,16'h0000,"R9"},
        '{1'b1,1'b1,3'd6,32'h0000_000F,2'd0,1'b0,4'hA,4'h2,1'b1,4'h0,4'h0,16'h0000,"R9"},
        '{1'b1,1'b1,3'd3,32'h0000_0002,2'd0,1'b0,4'hA,4'h2,1'b0,4'h2,4'h0,16'h0000,"R11"},
        '{1'b1,1'b1,3'd1,32'h0000_0001,2'd0,1'b0,4'hA,4'h2,1'b0,4'h0,4'h1,16'h0000,"R11"},
        '{1'b1,1'b0,3'd3,32'h0000_0000,2'd0,1'b0,4'hA,4'h2,1'b0,4'h0,4'h0,16'h000A,"R8"},
        '{1'b1,1'b0,3'd0,32'h0000_0000,2'd3,1'b0,4'hA,4'h2,1'b0,4'h0,4'h0,16'h0A23,"R8"}
    };

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        acc_valid = 1'b0; acc_write = 1'b0; acc_idx = '0;
        acc_wdata = '0;   acc_cpu = '0;     tick = 1'b0;
    endtask

    initial begin
        #100000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state during reset
        chk("R1", "ipi_irq", {60'h0, ipi_irq}, 64'h0);
        chk("R1", "tmr_irq", {60'h0, tmr_irq}, 64'h0);
        chk("R1", "rsp_valid", {63'h0, rsp_valid}, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "warn", {56'h0, warn_ipi_dup, warn_ipi_spur}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string t;
            v = VEC[i];
            t = $sformatf("%s", v.tag);
            acc_valid = v.acc; acc_write = v.wr; acc_idx = v.idx;
            acc_wdata = {32'h0, v.wd}; acc_cpu = v.cpu; tick = v.tk;
            @(negedge clk);
            idle();
            // R10: response pulse and outputs follow the pending masks
            chk(t, "rsp_valid", {63'h0, rsp_valid}, {63'h0, v.acc});
            chk(t, "ipi_irq", {60'h0, ipi_irq}, {60'h0, v.e_ipi});
            chk(t, "tmr_irq", {60'h0, tmr_irq}, {60'h0, v.e_tmr});
            chk(t, "warn_dup", {60'h0, warn_ipi_dup}, {60'h0, v.e_dup});
            chk(t, "warn_spur", {60'h0, warn_ipi_spur}, {60'h0, v.e_spur});
            if (v.acc) chk(t, "rsp_err", {63'h0, rsp_err}, {63'h0, v.e_err});
            if (v.acc && !v.wr) chk(t, "rsp_rdata", rsp_rdata, {48'h0, v.e_rd});
        end

        // R10: idle cycle produces no response and clears strobes
        @(negedge clk);
        chk("R10", "rsp_valid idle", {63'h0, rsp_valid}, 64'h0);
        chk("R11", "warn idle", {56'h0, warn_ipi_dup, warn_ipi_spur}, 64'h0);

        // R1: mid-run reset clears pending state
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "ipi after reset", {60'h0, ipi_irq}, 64'h0);
        chk("R1", "tmr after reset", {60'h0, tmr_irq}, 64'h0);

        // R8: control read after reset shows empty masks
        acc_valid = 1'b1; acc_write = 1'b0; acc_idx = 3'd0; acc_cpu = 2'd1;
        @(negedge clk);
        idle();
        chk("R8", "ctrl read empty", rsp_rdata, 64'h1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule